// File: doc/BRIEF.md
# Supply Guard: Power-Fail Protect and Backup Switchover Controller

This block supervises the supply of a battery-backed static memory. An external converter delivers periodic supply-voltage codes on a valid/ready input stream. The block sorts every accepted code against a set of thresholds and runs a four-state machine: unarmed, normal, protected and on-backup. From that state it drives four plain control flags. These flags enable memory access, block writes, hold the memory's inputs ignored and its data outputs in high impedance, and select the backup cell as the array supply.

Backup switchover stays disconnected until the supply first reaches an arming level. After that, a one-time latch keeps it armed. A state change is accepted only after the same move is requested by a fixed number of consecutive samples. This filters glitches on the converter output. Two threshold sets are available, one for each device variant, and a parameter chooses between them.

The input stream never applies back-pressure: `smp_ready` is held high, and a code is taken on every clock edge where `smp_valid` is high.

Top module: `supply_guard`

## Requirements
- R1: During and right after reset, the state is unarmed, with `access_en`=0, `wr_protect`=1, `bus_float`=1 and `backup_sel`=0.
- R2: From unarmed, FILT_N consecutive samples with code >= ARM_LVL (default 700) set the backup-arm latch and move to protected. After that, the latch never clears, so every later drop below the switchover level selects backup.
- R3: While the latch is clear, no supply code, however low, sets `backup_sel`.
- R4: From protected, the state becomes normal only after FILT_N consecutive codes >= the full-operation level. The default variant uses 950. Codes between the protect level and the full level keep the block protected.
- R5: From normal, FILT_N consecutive codes below the protect level (900 in the default variant) move to protected. Codes from the protect level up to the full level keep normal operation, which gives the hysteresis.
- R6: `access_en` is 1 exactly in the normal state. `wr_protect` and `bus_float` are 1 in every other state. `backup_sel` is 1 only in the on-backup state.
- R7: From protected, with the latch set, FILT_N consecutive codes below SW_LVL (default 600) move to on-backup.
- R8: From on-backup, the state returns to protected only after FILT_N consecutive codes >= SW_LVL+SW_HYST (default 610). Codes from 600 to 609 keep backup selected.
- R9: A pending move completes on the FILT_N-th (default 3) consecutive qualifying sample. Any sample that does not request the same move restarts the count. Clock cycles without `smp_valid` neither count nor break the run.
- R10: `smp_ready` is always 1. The block's state changes only on edges where a sample is accepted.
- R11: With VARIANT=1, the full level is 900 and the protect level is 850. With VARIANT=0, they are 950 and 900.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Supply code valid |
| smp_ready | output | 1 | Always 1; no back-pressure |
| smp_code | input | CODE_W | Supply voltage in converter code units |
| access_en | output | 1 | Memory access allowed |
| wr_protect | output | 1 | Writes blocked |
| bus_float | output | 1 | Inputs ignored, data outputs high impedance |
| backup_sel | output | 1 | Array powered from the backup cell |

## Verification
The supply is swept down and up through every threshold. This includes codes just inside each hysteresis band, which separates the upper and lower crossing of each pair. A drop below switchover before arming, compared with the same drop after arming, shows whether the one-time latch is really gating backup. Short runs broken by an opposing sample, and runs spread across idle cycles, tell apart a true consecutive-sample filter from one that counts total samples or clock cycles. A second instance built with the other variant receives the same stream, so a code between the two full levels separates the two threshold sets.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    ST_UNARMED = 2'd0,
    ST_NORMAL  = 2'd1,
    ST_PROTECT = 2'd2,
    ST_BACKUP  = 2'd3
  } sg_state_e;
endpackage

// File: rtl/sg_zone.sv
module sg_zone
  import sg_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter logic [CODE_W-1:0] ARM_C  = '0,
  parameter logic [CODE_W-1:0] FULL_C = '0,
  parameter logic [CODE_W-1:0] PROT_C = '0,
  parameter logic [CODE_W-1:0] SWLO_C = '0,
  parameter logic [CODE_W-1:0] SWHI_C = '0
) (
  input  sg_state_e         state_i,
  input  logic              armed_i,
  input  logic [CODE_W-1:0] code_i,
  output sg_state_e         cand_o
);
  // Desired next state for one sample, before glitch filtering
  always_comb begin
    cand_o = state_i;
    case (state_i)
      ST_UNARMED: if (code_i >= ARM_C) cand_o = ST_PROTECT;
      ST_NORMAL:  if (code_i < PROT_C) cand_o = ST_PROTECT;
      ST_PROTECT: begin
        if (code_i >= FULL_C) cand_o = ST_NORMAL;
        else if (armed_i && code_i < SWLO_C) cand_o = ST_BACKUP;
      end
      ST_BACKUP:  if (code_i >= SWHI_C) cand_o = ST_PROTECT;
      default:    cand_o = ST_UNARMED;
    endcase
  end
endmodule

// File: rtl/sg_qualify.sv
module sg_qualify
  import sg_pkg::*;
#(
  parameter int FILT_N = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_i,
  input  logic      want_i,
  input  sg_state_e tgt_i,
  output logic      fire_o
);
  localparam int CNT_W = $clog2(FILT_N + 1);

  logic [CNT_W-1:0] cnt_q;
  sg_state_e        pend_q;
  logic [CNT_W:0]   run;
  logic             match;

  assign match  = (cnt_q != '0) && (tgt_i == pend_q);
  assign run    = match ? ({1'b0, cnt_q} + (CNT_W+1)'(1)) : (CNT_W+1)'(1);
  assign fire_o = step_i && want_i && (run >= (CNT_W+1)'(FILT_N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= ST_UNARMED;
    end else if (step_i) begin
      if (!want_i || fire_o) begin
        cnt_q <= '0;
      end else begin
        cnt_q  <= run[CNT_W-1:0];
        pend_q <= tgt_i;
      end
    end
  end

  // R9
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(FILT_N));
endmodule

// File: rtl/sg_fresh.sv
module sg_fresh (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_q <= 1'b0;
    else if (set_i) armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  // R2
  arm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import sg_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int VARIANT = 0,
  parameter int FULL_A  = 950,
  parameter int PROT_A  = 900,
  parameter int FULL_B  = 900,
  parameter int PROT_B  = 850,
  parameter int SW_LVL  = 600,
  parameter int SW_HYST = 10,
  parameter int ARM_LVL = 700,
  parameter int FILT_N  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [CODE_W-1:0] smp_code,
  output logic              access_en,
  output logic              wr_protect,
  output logic              bus_float,
  output logic              backup_sel
);
  localparam logic [CODE_W-1:0] FULL_C = CODE_W'((VARIANT == 0) ? FULL_A : FULL_B);
  localparam logic [CODE_W-1:0] PROT_C = CODE_W'((VARIANT == 0) ? PROT_A : PROT_B);
  localparam logic [CODE_W-1:0] SWLO_C = CODE_W'(SW_LVL);
  localparam logic [CODE_W-1:0] SWHI_C = CODE_W'(SW_LVL + SW_HYST);
  localparam logic [CODE_W-1:0] ARM_C  = CODE_W'(ARM_LVL);

  sg_state_e st_q;
  sg_state_e cand;
  logic      armed;
  logic      fire;

  assign smp_ready = 1'b1;

  sg_zone #(
    .CODE_W(CODE_W), .ARM_C(ARM_C), .FULL_C(FULL_C),
    .PROT_C(PROT_C), .SWLO_C(SWLO_C), .SWHI_C(SWHI_C)
  ) u_zone (
    .state_i(st_q), .armed_i(armed), .code_i(smp_code), .cand_o(cand)
  );

  sg_qualify #(.FILT_N(FILT_N)) u_qual (
    .clk(clk), .rst_n(rst_n), .step_i(smp_valid),
    .want_i(cand != st_q), .tgt_i(cand), .fire_o(fire)
  );

  sg_fresh u_fresh (
    .clk(clk), .rst_n(rst_n),
    .set_i(fire && (st_q == ST_UNARMED)), .armed_o(armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= ST_UNARMED;
    else if (fire) st_q <= cand;
  end

  assign access_en  = (st_q == ST_NORMAL);
  assign wr_protect = (st_q != ST_NORMAL);
  assign bus_float  = (st_q != ST_NORMAL);
  assign backup_sel = (st_q == ST_BACKUP);

  // R3
  backup_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backup_sel |-> armed);
  // R10
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(access_en) && $stable(backup_sel));
  // R4
  normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_en) |-> $past(smp_valid && smp_code >= FULL_C));
  // R5
  normal_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(access_en) |-> $past(smp_valid && smp_code < PROT_C));
  // R7
  backup_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backup_sel) |-> $past(smp_valid && smp_code < SWLO_C));
  // R8
  backup_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(backup_sel) |-> $past(smp_valid && smp_code >= SWHI_C));
endmodule

// File: tb/supply_guard_bench.sv
`timescale 1ns/1ps
module supply_guard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic [9:0] smp_code = '0;
  logic       smp_ready, access_en, wr_protect, bus_float, backup_sel;
  logic       lo_ready, lo_access, lo_wp, lo_float, lo_backup;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [3:0] E_OFF = 4'b0110; // access, wp, float, backup
  localparam logic [3:0] E_NRM = 4'b1000;
  localparam logic [3:0] E_BKP = 4'b0111;

  typedef struct {
    logic [3:0] exp;
    bit         lo_chk;
    bit         lo_exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  supply_guard u_supply_guard (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_code(smp_code), .access_en(access_en), .wr_protect(wr_protect),
    .bus_float(bus_float), .backup_sel(backup_sel)
  );

  supply_guard #(.VARIANT(1)) u_supply_guard_lo (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(lo_ready),
    .smp_code(smp_code), .access_en(lo_access), .wr_protect(lo_wp),
    .bus_float(lo_float), .backup_sel(lo_backup)
  );

  task automatic check4(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {access_en, wr_protect, bus_float, backup_sel};
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s flags actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send(input int code, input logic [3:0] exp, input string tag,
                      input bit lc = 1'b0, input bit le = 1'b0);
    item_t it;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_code  = 10'(code);
    it.exp = exp; it.lo_chk = lc; it.lo_exp = le; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: after each accepted sample, compare the flags with the queue head
  initial begin
    forever begin
      bit took;
      item_t it;
      @(posedge clk);
      took = smp_valid;
      @(negedge clk);
      if (took && sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check4(it.exp, it.tag);
        if (it.lo_chk) begin
          n_run++;
          if (lo_access !== it.lo_exp) begin
            n_bad++;
            $display("FAIL %s variant access actual=%b expected=%b",
                     it.tag, lo_access, it.lo_exp);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    check4(E_OFF, "R1 reset");
    n_run++;
    if (smp_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R10 ready actual=%b expected=1", smp_ready);
    end
    // R3: low supply before arming never selects backup
    repeat (3) send(400, E_OFF, "R3 unarmed 400");
    repeat (3) send(550, E_OFF, "R3 unarmed 550");
    repeat (3) send(650, E_OFF, "R3 unarmed 650");
    // R2: arm at the trip level
    repeat (3) send(720, E_OFF, "R2 arming");
    // R7 with idle gaps (R9)
    send(590, E_OFF, "R7 first low"); idle(3);
    send(590, E_OFF, "R7 second low"); idle(2);
    send(590, E_BKP, "R7 backup on");
    // R8: inside the hysteresis band
    repeat (4) send(605, E_BKP, "R8 band holds");
    send(615, E_BKP, "R8 leave 1");
    send(615, E_BKP, "R8 leave 2");
    send(615, E_OFF, "R8 back to protect");
    // R4 and R11: 920 is full for the low variant only
    send(920, E_OFF, "R4 below full");
    send(920, E_OFF, "R4 below full");
    send(920, E_OFF, "R11 variant split", 1'b1, 1'b1);
    send(950, E_OFF, "R4 full 1");
    send(950, E_OFF, "R4 full 2");
    send(950, E_NRM, "R4 normal on");
    // R5 hysteresis band keeps normal
    repeat (3) send(920, E_NRM, "R5 band holds");
    // R9 broken run
    send(880, E_NRM, "R9 run 1");
    send(880, E_NRM, "R9 run 2");
    send(930, E_NRM, "R9 run broken");
    send(880, E_NRM, "R5 drop 1");
    send(880, E_NRM, "R5 drop 2");
    send(880, E_OFF, "R5 protect on", 1'b1, 1'b1);
    // R11: low variant leaves normal below 850
    send(840, E_OFF, "R11 lo drop 1");
    send(840, E_OFF, "R11 lo drop 2");
    send(840, E_OFF, "R11 lo protect", 1'b1, 1'b0);
    // R6 and R9: run spread across idle cycles
    send(560, E_OFF, "R6 r9 spread 1"); idle(5);
    send(560, E_OFF, "R6 r9 spread 2"); idle(1);
    send(560, E_BKP, "R6 backup flags");
    // R10: idle cycles alone change nothing
    idle(6);
    check4(E_BKP, "R10 idle hold");
    // R2: latch stays set after a round trip
    repeat (2) send(650, E_BKP, "R2 rise");
    send(650, E_OFF, "R2 protect again");
    repeat (2) send(500, E_OFF, "R2 fall");
    send(500, E_BKP, "R2 latch kept");
    idle(3);
    n_run++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9 scoreboard left=%0d expected=0", sb_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule